// File: doc/BRIEF.md
# Self-Locking Test Pattern Checker

This block judges a stream of received test words against one of two known sequence rules: an incrementing counter or a pseudo-random linear feedback shift register. It is given no starting value. Every accepted word becomes the basis for predicting the next one, so the checker follows whatever sequence arrives, from any starting point. It is placed on the receive side of a link or data path under test, and a control layer reads back its error vector and its result-valid flag.

Words count only on cycles where the strobe is high. The first two words accepted after a (re)start only establish the lock. Every word after that is compared with the prediction, and any bit that differs is recorded in a sticky error vector. The error vector is cleared in three cases: the checker is disabled, it is re-enabled, or the pattern selection changes.

Top module: `seq_lock_checker`

## Requirements
- R1: With `pick_cnt_i`=1 the word predicted after an accepted word x is x+1 modulo 2^WORD_W. With `pick_cnt_i`=0 it is {x[WORD_W-2:0], parity(x & TAP)}, where TAP is a fixed maximal-length tap mask per width (16'hD008 for WORD_W=16). Feeding one pattern while the other is selected is reported as an error.
- R2: `verdict_vld_o` is 0 after reset and after every restart. It goes to 1 on the cycle after the second word accepted since the restart. The first two words never set error bits.
- R3: Each word accepted after the lock ORs (predicted XOR received) into `err_vec_o`. Bits that are set stay set while the checker remains enabled and the selection is unchanged.
- R4: A cycle with `enable_i`=0 clears `err_vec_o` and drops `verdict_vld_o` by the next cycle. After re-enabling, the lock starts again from nothing.
- R5: An all-ones word that breaks the sequence sets its mismatching bits. In counter mode, all-ones followed by zero is correct (wrap).
- R6: Cycles with `word_vld_i`=0 neither advance the prediction nor change `err_vec_o` or `verdict_vld_o`.
- R7: `err_any_o` equals the OR of all bits of `err_vec_o` in the same cycle.
- R8: A change of `pick_cnt_i` while enabled restarts the checker: errors are cleared and `verdict_vld_o` is 0 on the next cycle. A word strobed in that same cycle is discarded.
- R9: The checker locks onto a sequence that starts at any value, with no seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Checker active when 1 |
| pick_cnt_i | input | 1 | 1 = counter rule, 0 = shift-register rule |
| word_i | input | WORD_W | Received test word |
| word_vld_i | input | 1 | Strobe: `word_i` is valid this cycle |
| err_vec_o | output | WORD_W | Sticky per-bit mismatch vector |
| verdict_vld_o | output | 1 | Result is meaningful (lock reached) |
| err_any_o | output | 1 | OR of `err_vec_o` |

## Verification
A restart and a word arrival can land in the same cycle. In that case the restart must win, and the word must be neither compared nor counted toward the lock. The bench provokes this by flipping the pattern selection on the same cycle as it strobes a word, while the error vector is already non-zero. It then checks that the errors are gone on the next cycle. It also checks that lock needs two further words, not one, which shows that the coinciding word was thrown away. The same pairing is exercised with the disable input against a locked stream.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

   typedef enum logic [1:0] {
      PH_EMPTY  = 2'd0,
      PH_PRIMED = 2'd1,
      PH_LOCKED = 2'd2
   } lock_phase_t;

   localparam int unsigned SEQ_W_MIN = 1;
   localparam int unsigned SEQ_W_MAX = 32;

   // Maximal-length feedback masks; bit k set means stage k+1 feeds parity.
   function automatic logic [31:0] lfsr_taps(input int unsigned w);
      logic [31:0] m;
      case (w)
         2:  m = 32'h0000_0003;
         3:  m = 32'h0000_0006;
         4:  m = 32'h0000_000C;
         5:  m = 32'h0000_0014;
         6:  m = 32'h0000_0030;
         7:  m = 32'h0000_0060;
         8:  m = 32'h0000_00B8;
         9:  m = 32'h0000_0110;
         10: m = 32'h0000_0240;
         11: m = 32'h0000_0500;
         12: m = 32'h0000_0829;
         13: m = 32'h0000_100D;
         14: m = 32'h0000_2015;
         15: m = 32'h0000_6000;
         16: m = 32'h0000_D008;
         17: m = 32'h0001_2000;
         18: m = 32'h0002_0400;
         19: m = 32'h0004_0023;
         20: m = 32'h0009_0000;
         21: m = 32'h0014_0000;
         22: m = 32'h0030_0000;
         23: m = 32'h0042_0000;
         24: m = 32'h00E1_0000;
         25: m = 32'h0120_0000;
         26: m = 32'h0200_0023;
         27: m = 32'h0400_0013;
         28: m = 32'h0900_0000;
         29: m = 32'h1400_0000;
         30: m = 32'h2000_0029;
         31: m = 32'h4800_0000;
         32: m = 32'h8020_0003;
         default: m = 32'h0000_0001;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/seqchk_predict.sv
module seqchk_predict #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         take_i,
   input  logic         pick_cnt_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] expect_o
);
   import seqchk_pkg::*;

   localparam logic [31:0] TAP_ALL = lfsr_taps(W);
   localparam logic [W-1:0] TAP    = TAP_ALL[W-1:0];

   logic [W-1:0] last_q;
   logic [W-1:0] next_cnt;
   logic [W-1:0] next_lfsr;

   generate
      if (W < SEQ_W_MIN || W > SEQ_W_MAX) begin : g_width_bad
         $error("seqchk_predict: W must lie between 1 and 32");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         last_q <= '0;
      end else if (take_i) begin
         last_q <= word_i;
      end
   end

   assign next_cnt = last_q + W'(1);

   generate
      if (W == 1) begin : g_single
         // one stage: the only maximal sequence toggles
         assign next_lfsr = ~last_q;
      end else begin : g_shift
         assign next_lfsr = {last_q[W-2:0], ^(last_q & TAP)};
      end
   endgenerate

   assign expect_o = pick_cnt_i ? next_cnt : next_lfsr;

endmodule

// File: rtl/seqchk_lock.sv
module seqchk_lock (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     enable_i,
   input  logic                     pick_cnt_i,
   input  logic                     vld_i,
   output seqchk_pkg::lock_phase_t  phase_o,
   output logic                     restart_o,
   output logic                     take_o,
   output logic                     judge_o
);
   import seqchk_pkg::*;

   lock_phase_t phase_q;
   logic        sel_q;

   assign restart_o = !enable_i || (pick_cnt_i != sel_q);
   assign take_o    = vld_i && !restart_o;
   assign judge_o   = take_o && (phase_q == PH_LOCKED);
   assign phase_o   = phase_q;

   always_ff @(posedge clk_i) begin
      sel_q <= pick_cnt_i;
      if (rst_i) begin
         phase_q <= PH_EMPTY;
      end else if (restart_o) begin
         phase_q <= PH_EMPTY;
      end else if (vld_i) begin
         case (phase_q)
            PH_EMPTY:  phase_q <= PH_PRIMED;
            PH_PRIMED: phase_q <= PH_LOCKED;
            default:   phase_q <= PH_LOCKED;
         endcase
      end
   end

   assert_two_words_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(phase_q == PH_LOCKED) |-> ($past(phase_q) == PH_PRIMED && $past(vld_i)));

   assert_off_drops_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !enable_i |=> (phase_q == PH_EMPTY));

   assert_reselect_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (enable_i && pick_cnt_i != $past(pick_cnt_i)) |=> (phase_q == PH_EMPTY));

endmodule

// File: rtl/seqchk_sticky.sv
module seqchk_sticky #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clear_i,
   input  logic         judge_i,
   input  logic [W-1:0] expect_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] acc_o
);
   logic [W-1:0] acc_q;
   logic [W-1:0] diff;

   assign diff = expect_i ^ word_i;

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i) begin
         acc_q <= '0;
      end else if (judge_i) begin
         acc_q <= acc_q | diff;
      end
   end

   assign acc_o = acc_q;

   assert_keep_bits_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clear_i && acc_q != '0) |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

   assert_gap_still_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clear_i && !judge_i) |=> $stable(acc_q));

   assert_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      clear_i |=> (acc_q == '0));

endmodule

// File: rtl/seq_lock_checker.sv
module seq_lock_checker #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              enable_i,
   input  logic              pick_cnt_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_vld_i,
   output logic [WORD_W-1:0] err_vec_o,
   output logic              verdict_vld_o,
   output logic              err_any_o
);
   import seqchk_pkg::*;

   lock_phase_t       phase;
   logic              restart;
   logic              take;
   logic              judge;
   logic [WORD_W-1:0] expect_w;
   logic [WORD_W-1:0] acc;

   seqchk_lock lock_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .enable_i   (enable_i),
      .pick_cnt_i (pick_cnt_i),
      .vld_i      (word_vld_i),
      .phase_o    (phase),
      .restart_o  (restart),
      .take_o     (take),
      .judge_o    (judge)
   );

   seqchk_predict #(.W(WORD_W)) predict_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .take_i     (take),
      .pick_cnt_i (pick_cnt_i),
      .word_i     (word_i),
      .expect_o   (expect_w)
   );

   seqchk_sticky #(.W(WORD_W)) sticky_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clear_i  (restart),
      .judge_i  (judge),
      .expect_i (expect_w),
      .word_i   (word_i),
      .acc_o    (acc)
   );

   assign err_vec_o     = acc;
   assign err_any_o     = |acc;
   assign verdict_vld_o = (phase == PH_LOCKED);

   assert_quiet_until_lock_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !verdict_vld_o |-> (err_vec_o == '0));

endmodule

// File: tb/seq_lock_checker_tb_top.sv
`timescale 1ns/1ps
module seq_lock_checker_tb_top;
   localparam int unsigned W = 16;
   localparam logic [15:0] TAP16 = 16'hD008;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic        sel = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] w   = '0;
   logic [15:0] errv;
   logic        verdict;
   logic        any;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 0;

   int          m_phase = 0;
   logic [15:0] m_last  = '0;
   logic [15:0] m_acc   = '0;
   logic        m_sel   = 1'b0;

   always #4 clk = ~clk;

   seq_lock_checker #(.WORD_W(W)) dut_i (
      .clk_i         (clk),
      .rst_i         (rst),
      .enable_i      (en),
      .pick_cnt_i    (sel),
      .word_i        (w),
      .word_vld_i    (vld),
      .err_vec_o     (errv),
      .verdict_vld_o (verdict),
      .err_any_o     (any)
   );

   function automatic logic [15:0] nx_cnt(input logic [15:0] x);
      return x + 16'd1;
   endfunction

   function automatic logic [15:0] nx_lfsr(input logic [15:0] x);
      return {x[14:0], ^(x & TAP16)};
   endfunction

   task automatic cmp16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp1(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one cycle: drive at a falling edge, step the model, wait for the next one
   task automatic tick(input logic e, input logic s, input logic v, input logic [15:0] d);
      bit restart;
      en = e; sel = s; vld = v; w = d;
      restart = !e || (s != m_sel);
      m_sel = s;
      if (restart) begin
         m_phase = 0;
         m_acc   = '0;
      end else if (v) begin
         if (m_phase == 2) m_acc |= (s ? nx_cnt(m_last) : nx_lfsr(m_last)) ^ d;
         m_last = d;
         if (m_phase < 2) m_phase++;
      end
      @(negedge clk);
   endtask

   task automatic put(input logic [15:0] d);
      tick(1'b1, sel, 1'b1, d);
   endtask

   task automatic idle(input int n);
      repeat (n) tick(en, sel, 1'b0, w);
   endtask

   task automatic check_all(input string tag);
      cmp1(tag, verdict, m_phase == 2);
      cmp16(tag, errv, m_acc);
      cmp1({tag, " R7"}, any, |m_acc);
   endtask

   task automatic t_reset;
      cmp1("R2 reset verdict", verdict, 1'b0);
      cmp16("R4 reset errv", errv, 16'h0000);
      cmp1("R7 reset any", any, 1'b0);
   endtask

   task automatic t_counter_lock;
      logic [15:0] x;
      tick(1'b1, 1'b1, 1'b0, 16'h0);
      put(16'h1234);
      cmp1("R2 one word", verdict, 1'b0);
      put(16'h1235);
      cmp1("R2 two words", verdict, 1'b1);
      x = 16'h1235;
      for (int i = 0; i < 8; i++) begin
         x = nx_cnt(x);
         put(x);
      end
      cmp16("R9 unseeded lock", errv, 16'h0000);
      check_all("R1 counter");
   endtask

   task automatic t_gaps;
      logic [15:0] x;
      x = m_last;
      for (int i = 0; i < 6; i++) begin
         x = nx_cnt(x);
         put(x);
         idle(3);
      end
      cmp16("R6 gaps", errv, 16'h0000);
      check_all("R6 gaps");
   endtask

   task automatic t_wrap;
      tick(1'b0, 1'b1, 1'b0, 16'h0);
      put(16'hFFFE);
      put(16'hFFFF);
      put(16'h0000);
      put(16'h0001);
      cmp16("R5 wrap", errv, 16'h0000);
      check_all("R5 wrap");
   endtask

   task automatic t_ones;
      put(16'h0002);
      put(16'hFFFF);
      cmp16("R5 ones", errv, 16'hFFFC);
      cmp1("R7 any", any, 1'b1);
      put(16'h0103);
      cmp16("R3 accumulate", errv, 16'hFFFF);
      put(16'h0104);
      cmp16("R3 sticky", errv, 16'hFFFF);
      check_all("R3");
   endtask

   task automatic t_disable;
      tick(1'b0, 1'b1, 1'b1, 16'h0105);
      cmp1("R4 off verdict", verdict, 1'b0);
      cmp16("R4 off errv", errv, 16'h0000);
      put(16'h5000);
      cmp1("R4 relock pending", verdict, 1'b0);
      put(16'h5001);
      put(16'h5002);
      check_all("R4 re-enable");
   endtask

   task automatic t_lfsr;
      logic [15:0] s;
      logic [15:0] bad;
      tick(1'b0, 1'b0, 1'b0, 16'h0);
      s = 16'hACE1;
      put(s);
      for (int i = 0; i < 15; i++) begin
         s = nx_lfsr(s);
         put(s);
      end
      cmp16("R1 lfsr clean", errv, 16'h0000);
      cmp1("R1 lfsr verdict", verdict, 1'b1);
      bad = s + 16'd1;
      put(bad);
      cmp16("R1 lfsr error", errv, nx_lfsr(s) ^ bad);
      check_all("R1 lfsr");
   endtask

   task automatic t_reselect;
      tick(1'b1, 1'b1, 1'b1, 16'h7777);
      cmp1("R8 verdict", verdict, 1'b0);
      cmp16("R8 errv", errv, 16'h0000);
      put(16'h7000);
      cmp1("R8 word dropped", verdict, 1'b0);
      put(16'h7001);
      cmp1("R8 relock", verdict, 1'b1);
      put(16'h7002);
      check_all("R8");
   endtask

   task automatic t_wrong_pattern;
      logic [15:0] s;
      tick(1'b0, 1'b1, 1'b0, 16'h0);
      s = 16'h0001;
      put(s);
      for (int i = 0; i < 6; i++) begin
         s = nx_lfsr(s);
         put(s);
      end
      cmp1("R1 wrong pattern", any, 1'b1);
      check_all("R1 wrong pattern");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_counter_lock();
      t_gaps();
      t_wrap();
      t_ones();
      t_disable();
      t_lfsr();
      t_reselect();
      t_wrong_pattern();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule